// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt requests for a cluster of up to four processors and presents each processor with a single interrupt level. Every processor owns a small register bank on a 32-bit register bus. Software uses that bank to post and retire its own software interrupts and the inter-processor interrupts sent to it. A shared global bank latches the device interrupt lines and holds a mask in which a 1 disables a source. It also holds a steering register that chooses which processor receives the unmasked device sources.

Each processor's level output is the highest level among its own pending bits and, if the steering register names that processor, the unmasked global sources. A separate non-maskable-interrupt output reports the memory-error line (device bit 31) while its mask bit is clear.

The bus port is a small state machine with two states. `BUS_IDLE` is the resting state. A read request moves it to `BUS_RESP`, which presents `bus_rdata` with `bus_rvalid` high for one cycle. From `BUS_RESP`, a further read stays in `BUS_RESP` and anything else returns to `BUS_IDLE`. Writes take effect at the clock edge on which they are presented and never leave `BUS_IDLE`.

Top module: `mpic_top`

## Requirements
- R1: A synchronous reset clears every per-processor pending word, the global pending word, the steering register (processor 0), all level outputs and `nmi`, and sets every global mask bit to 1.
- R2: A write to offset 0x08 of the bank at address `c*0x1000` sets the bits of processor c's pending word that are written as 1. Offset 0x00 of the same bank reads that pending word back, and the other banks are unchanged.
- R3: A write to offset 0x04 of a processor bank clears the bits written as 1. Bits written as 0 keep their value.
- R4: In the global bank at 0x4000, a write to offset 0x0C sets mask bits written as 1. A write to offset 0x08 clears mask bits written as 1. Offset 0x04 reads the mask.
- R5: Global offset 0x00 reads the device lines as they were latched on the previous clock edge.
- R6: Global offset 0x10 is the steering register. A write stores `bus_wdata[1:0]`, and a read returns that value zero-extended.
- R7: Pending bit k stands for level k when 1 ≤ k ≤ 15 and for level k−16 when 17 ≤ k ≤ 31. Bits 0 and 16 stand for no level. `cpu_level[4c+3:4c]` shows the highest level held by processor c, one clock edge after the state that causes it.
- R8: A global pending bit whose mask bit is 0 counts towards the level of the processor named by the steering register, and of no other processor.
- R9: `nmi` is 1 one edge after global pending bit 31 is 1 while mask bit 31 is 0.
- R10: Reads of write-only offsets (processor 0x04 and 0x08, global 0x08 and 0x0C) and of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R11: `bus_rvalid` is 1 exactly in the cycle after each read request, together with its data, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_irq | input | 32 | Device interrupt lines, level sensitive |
| bus_en | input | 1 | Bus request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| cpu_level | output | 16 | Four 4-bit levels, processor 0 in the low nibble |
| nmi | output | 1 | Memory-error non-maskable interrupt |

## Verification
A write changes register state at the edge that takes it, so a read issued on the next cycle already returns the new value. The level outputs and `nmi` follow one edge later. A device line change reaches the global pending word one edge after it is applied and the level outputs one edge after that. The bench drives on falling edges and compares on falling edges. It checks read data on the falling edge after the request edge, levels one further falling edge after a write, and waits two falling edges after changing a device line before it checks a level or `nmi`.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
    localparam int WORD_W = 32;
    localparam int LVL_W  = 4;

    localparam logic [11:0] OFF_PEND  = 12'h000;
    localparam logic [11:0] OFF_CLR   = 12'h004;
    localparam logic [11:0] OFF_SET   = 12'h008;
    localparam logic [11:0] OFF_GMASK = 12'h004;
    localparam logic [11:0] OFF_GMCLR = 12'h008;
    localparam logic [11:0] OFF_GMSET = 12'h00C;
    localparam logic [11:0] OFF_GTGT  = 12'h010;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    function automatic logic [LVL_W-1:0] bit_level(input int k);
        if (k < 16) return LVL_W'(k);
        return LVL_W'(k - 16);
    endfunction
endpackage

// File: rtl/mpic_cpu_bank.sv
module mpic_cpu_bank
    import mpic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst)         pend <= '0;
        else if (set_we) pend <= pend | wdata;
        else if (clr_we) pend <= pend & ~wdata;
    end

    // R2: bits written as 1 to the set word are present afterwards
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((pend & $past(wdata)) == $past(wdata)));
    // R3: bits written as 1 to the clear word are gone afterwards
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((pend & $past(wdata)) == '0));
    // R3: zeros written never disturb the other bits
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((pend & ~$past(wdata)) == ($past(pend) & ~$past(wdata))));
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(pend));
endmodule

// File: rtl/mpic_global_bank.sv
module mpic_global_bank
    import mpic_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] dev_irq,
    input  logic              mset_we,
    input  logic              mclr_we,
    input  logic              tgt_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] gpend,
    output logic [WORD_W-1:0] mask,
    output logic [TGT_W-1:0]  target
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gpend  <= '0;
            mask   <= '1;
            target <= '0;
        end else begin
            gpend <= dev_irq;
            if (mset_we)      mask <= mask | wdata;
            else if (mclr_we) mask <= mask & ~wdata;
            if (tgt_we) target <= wdata[TGT_W-1:0];
        end
    end

    // R4: the mask moves only on mask-set or mask-clear writes
    a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (!mset_we && !mclr_we) |=> $stable(mask));
    a_r4_mask_set: assert property (@(posedge clk) disable iff (rst)
        mset_we |=> ((mask & $past(wdata)) == $past(wdata)));
    // R6: steering register holds between writes
    a_r6_target_hold: assert property (@(posedge clk) disable iff (rst)
        !tgt_we |=> $stable(target));
endmodule

// File: rtl/mpic_level_enc.sv
module mpic_level_enc
    import mpic_pkg::*;
(
    input  logic [WORD_W-1:0] vec,
    output logic [LVL_W-1:0]  lvl
);
    always_comb begin
        lvl = '0;
        for (int k = 1; k < WORD_W; k++) begin
            if (vec[k] && (bit_level(k) > lvl)) lvl = bit_level(k);
        end
    end

    // R7: a zero level only when no level-carrying bit is set
    always_comb begin
        a_r7_zero_level: assert ((lvl == '0) == ((vec & ~32'h0001_0001) == '0));
    end
endmodule

// File: rtl/mpic_top.sv
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int ADDR_W    = 15,
    parameter int PAGE_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     dev_irq,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    output logic [NCPU*LVL_W-1:0] cpu_level,
    output logic                  nmi
);
    localparam int PAGE_W   = ADDR_W - PAGE_BITS;
    localparam int TGT_W    = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam int GLB_PAGE = NCPU;

    logic [PAGE_W-1:0]    page;
    logic [11:0]          off;
    logic                 wr_req, rd_req;
    logic                 glb_hit;
    logic [WORD_W-1:0]    cpu_pend [NCPU];
    logic [WORD_W-1:0]    gpend, gmask, gsrc;
    logic [TGT_W-1:0]     target;
    logic [WORD_W-1:0]    rd_word;
    bus_state_t           state_q, state_d;

    assign page    = bus_addr[ADDR_W-1:PAGE_BITS];
    assign off     = 12'(bus_addr[PAGE_BITS-1:0]);
    assign wr_req  = bus_en && bus_we;
    assign rd_req  = bus_en && !bus_we;
    assign glb_hit = (page == PAGE_W'(GLB_PAGE));
    assign gsrc    = gpend & ~gmask;

    // ---------------- per-processor banks and level outputs ----------------
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic               hit;
        logic [WORD_W-1:0]  vec;
        logic [LVL_W-1:0]   lvl;

        assign hit = wr_req && (page == PAGE_W'(c));
        assign vec = cpu_pend[c] | ((target == TGT_W'(c)) ? gsrc : '0);

        mpic_cpu_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_we (hit && (off == OFF_SET)),
            .clr_we (hit && (off == OFF_CLR)),
            .wdata  (bus_wdata),
            .pend   (cpu_pend[c])
        );

        mpic_level_enc u_enc (
            .vec (vec),
            .lvl (lvl)
        );

        always_ff @(posedge clk) begin
            if (rst) cpu_level[c*LVL_W +: LVL_W] <= '0;
            else     cpu_level[c*LVL_W +: LVL_W] <= lvl;
        end

        // R8: a processor not named by the steering register never sees
        // a global source above its own pending bits
        a_r8_steer_only: assert property (@(posedge clk) disable iff (rst)
            (target != TGT_W'(c) && cpu_pend[c] == '0 && !$rose(rst))
            |=> (cpu_level[c*LVL_W +: LVL_W] == '0) || ($past(target) == TGT_W'(c))
                || ($past(cpu_pend[c]) != '0));
    end

    // ---------------- global bank ----------------
    mpic_global_bank #(.TGT_W(TGT_W)) u_glb (
        .clk     (clk),
        .rst     (rst),
        .dev_irq (dev_irq),
        .mset_we (wr_req && glb_hit && (off == OFF_GMSET)),
        .mclr_we (wr_req && glb_hit && (off == OFF_GMCLR)),
        .tgt_we  (wr_req && glb_hit && (off == OFF_GTGT)),
        .wdata   (bus_wdata),
        .gpend   (gpend),
        .mask    (gmask),
        .target  (target)
    );

    always_ff @(posedge clk) begin
        if (rst) nmi <= 1'b0;
        else     nmi <= gpend[WORD_W-1] && !gmask[WORD_W-1];
    end

    // ---------------- read decode ----------------
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (page == PAGE_W'(c) && off == OFF_PEND) rd_word = cpu_pend[c];
        end
        if (glb_hit) begin
            unique case (off)
                OFF_PEND:  rd_word = gpend;
                OFF_GMASK: rd_word = gmask;
                OFF_GTGT:  rd_word = WORD_W'(target);
                default:   ;
            endcase
        end
    end

    // ---------------- bus response state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_word;
    end

    assign bus_rvalid = (state_q == BUS_RESP);

    // R11: response exactly one cycle after each read request
    a_r11_resp: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> bus_rvalid);
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !bus_rvalid);
    // R9: nmi needs the memory-error source unmasked on the previous edge
    a_r9_nmi_mask: assert property (@(posedge clk) disable iff (rst)
        (gmask[WORD_W-1] && !$rose(rst)) |=> !nmi);
endmodule

// File: tb/mpic_top_bench.sv
module mpic_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dev_irq = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] cpu_level;
    logic        nmi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mpic_top u_mpic_top (
        .clk(clk), .rst(rst), .dev_irq(dev_irq),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .cpu_level(cpu_level), .nmi(nmi)
    );

    // op: 0 write, 1 read and compare, 2 wait one cycle and compare levels
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        {2'd1, 16'h0000, 32'h0,          32'h0,          8'd1},
        {2'd1, 16'h4004, 32'h0,          32'hFFFF_FFFF,  8'd1},
        {2'd0, 16'h1008, 32'h0000_0020,  32'h0,          8'd2},
        {2'd1, 16'h1000, 32'h0,          32'h0000_0020,  8'd2},
        {2'd1, 16'h0000, 32'h0,          32'h0,          8'd2},
        {2'd2, 16'h0000, 32'h0,          32'h0000_0050,  8'd7},
        {2'd0, 16'h1008, 32'h4000_0000,  32'h0,          8'd2},
        {2'd2, 16'h0000, 32'h0,          32'h0000_00E0,  8'd7},
        {2'd0, 16'h1004, 32'h0000_0000,  32'h0,          8'd3},
        {2'd1, 16'h1000, 32'h0,          32'h4000_0020,  8'd3},
        {2'd0, 16'h1004, 32'h4000_0000,  32'h0,          8'd3},
        {2'd1, 16'h1000, 32'h0,          32'h0000_0020,  8'd3},
        {2'd1, 16'h1004, 32'h0,          32'h0,          8'd10},
        {2'd1, 16'h1008, 32'h0,          32'h0,          8'd10},
        {2'd0, 16'h4008, 32'h0000_FFFF,  32'h0,          8'd4},
        {2'd1, 16'h4004, 32'h0,          32'hFFFF_0000,  8'd4},
        {2'd0, 16'h400C, 32'h0000_0001,  32'h0,          8'd4},
        {2'd1, 16'h4004, 32'h0,          32'hFFFF_0001,  8'd4},
        {2'd1, 16'h4008, 32'h0,          32'h0,          8'd10},
        {2'd0, 16'h4010, 32'hFFFF_FFFE,  32'h0,          8'd6},
        {2'd1, 16'h4010, 32'h0,          32'h0000_0002,  8'd6},
        {2'd1, 16'h5000, 32'h0,          32'h0,          8'd10},
        {2'd0, 16'h5004, 32'hFFFF_FFFF,  32'h0,          8'd10},
        {2'd1, 16'h4004, 32'h0,          32'hFFFF_0001,  8'd10},
        {2'd0, 16'h0008, 32'h0001_0001,  32'h0,          8'd7},
        {2'd2, 16'h0000, 32'h0,          32'h0000_0050,  8'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[14:0]; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[14:0];
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 levels", {16'h0, cpu_level}, 32'h0);
        check("R1 nmi", {31'h0, nmi}, 32'h0);
        check("R11 idle", {31'h0, bus_rvalid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                2'd0: wr(VECS[i].addr, VECS[i].data);
                2'd1: begin
                    rd(VECS[i].addr, r);
                    check($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].exp);
                end
                default: begin
                    @(negedge clk);
                    check($sformatf("R%0d vec%0d", VECS[i].req, i), {16'h0, cpu_level}, VECS[i].exp);
                end
            endcase
        end

        // R10: unmapped write left processor 0 untouched except the set bits
        rd(16'h0000, r);
        check("R10 unmapped write", r, 32'h0001_0001);
        wr(16'h0004, 32'hFFFF_FFFF);
        wr(16'h1004, 32'hFFFF_FFFF);

        // R11: rvalid pulse then quiet
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 15'h4010;
        @(negedge clk);
        bus_en = 1'b0;
        check("R11 rvalid high", {31'h0, bus_rvalid}, 32'h1);
        @(negedge clk);
        check("R11 rvalid low", {31'h0, bus_rvalid}, 32'h0);

        // R5, R8: device bit 9 steered to processor 2
        dev_irq = 32'h0000_0200;
        repeat (2) @(negedge clk);
        check("R8 steer cpu2", {16'h0, cpu_level}, 32'h0000_0900);
        rd(16'h4000, r);
        check("R5 global pending", r, 32'h0000_0200);
        wr(16'h4010, 32'h0);
        @(negedge clk);
        check("R8 steer cpu0", {16'h0, cpu_level}, 32'h0000_0009);
        dev_irq = 32'h0010_0208;
        repeat (2) @(negedge clk);
        check("R7 highest wins", {16'h0, cpu_level}, 32'h0000_0009);
        wr(16'h400C, 32'h0000_0200);
        @(negedge clk);
        check("R4 masked source", {16'h0, cpu_level}, 32'h0000_0003);

        // R9: memory-error source
        dev_irq = 32'h8010_0208;
        repeat (2) @(negedge clk);
        check("R9 nmi masked", {31'h0, nmi}, 32'h0);
        check("R9 level masked", {16'h0, cpu_level}, 32'h0000_0003);
        wr(16'h4008, 32'h8000_0000);
        @(negedge clk);
        check("R9 nmi unmasked", {31'h0, nmi}, 32'h1);
        check("R9 level 15", {16'h0, cpu_level}, 32'h0000_000F);

        // R1: reset mid-run
        wr(16'h2008, 32'h0000_0002);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        dev_irq = '0;
        rd(16'h4004, r);
        check("R1 mask after reset", r, 32'hFFFF_FFFF);
        rd(16'h4010, r);
        check("R1 target after reset", r, 32'h0);
        rd(16'h2000, r);
        check("R1 pending after reset", r, 32'h0);
        check("R1 nmi after reset", {31'h0, nmi}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule